// File: doc/BRIEF.md
# Scan Chain Length Discovery Engine

This block drives a four-wire test access port (TCK, TMS, TDI, TDO) toward a single device and finds out, with no prior knowledge of the device, how long its instruction register and its boundary-scan register are. After a `start` pulse it resets the device's TAP controller and steers it into Shift-IR. It pushes a run of zeros long enough to clear any legal instruction register, then feeds ones and counts them until the first one comes back on TDO.

If the measured instruction length is usable, the engine resets the TAP again. It shifts an all-zeros instruction of exactly that length, which selects the boundary register, and passes it through Update-IR. It then repeats the flush-and-count method in Shift-DR. Both counts are reported together with two error flags, and a one-cycle `done` pulse marks the end once the device is parked in Run-Test/Idle.

Top module: `scanlen_probe`

## Requirements
- R1: During and right after reset, `tck`, `tms`, `tdi`, `busy`, `done`, both lengths and both error flags are 0.
- R2: While `busy`, `tck` toggles on every clock, so it runs at half the clock rate. `tms` and `tdi` change only in the cycle where `tck` falls, and `tdo` is sampled where `tck` rises. While idle, `tck` stays low.
- R3: Every measurement starts with five TCK cycles with TMS high, followed by one cycle with TMS low.
- R4: The instruction measurement enters Shift-IR, shifts IR_MAX zeros and then ones. `ir_len` is the number of ones shifted before the first 1 is sampled on TDO.
- R5: A measured instruction length of 0 or 1 sets `err_short`, keeps that value in `ir_len`, skips the data measurement and leaves `dr_len` at 0.
- R6: For a valid length L, the engine shifts L zeros into the instruction register with TMS high on the last bit and passes Update-IR. It then shifts DR_MAX zeros and then ones in Shift-DR, and `dr_len` is the count of ones shifted before a 1 is sampled.
- R7: If no 1 is sampled within bound+1 samples of the ones phase (bound being IR_MAX or DR_MAX), `err_timeout` is set and that length reads 0. A timeout in the instruction phase skips the data phase.
- R8: After the first 1 is seen, the engine exits the shift state with TMS high and passes the Update state. It returns to Run-Test/Idle (last TMS low) before `done`. `done` is a single-cycle pulse coinciding with `busy` falling.
- R9: `start` has no effect while `busy`: a run yields exactly one `done` and unchanged results.
- R10: Lengths up to IR_MAX and DR_MAX are reported exactly; the engine's outputs never exceed those bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin a measurement |
| busy | output | 1 | High while a measurement runs |
| done | output | 1 | One-cycle pulse at the end |
| ir_len | output | $clog2(IR_MAX+1) | Measured instruction register length |
| dr_len | output | $clog2(DR_MAX+1) | Measured boundary register length |
| err_timeout | output | 1 | No 1 returned within the bound |
| err_short | output | 1 | Instruction length below 2 |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data toward the device |
| tdo | input | 1 | Test data from the device |

## Verification
The bench builds the engine with IR_MAX = 8 and DR_MAX = 24. With these bounds, every legal instruction length from 2 to 8 and every boundary length from 1 to 24 can be swept against a behavioural TAP model. The small bounds also make the out-of-range lengths (9 and 25) cheap to reach, so both timeout paths are covered. A one-bit instruction register, a stuck-low TDO and a repeated `start` mid-run are added to cover the short-length, no-device and busy-ignore cases.

// File: rtl/scanlen_pkg.sv
package scanlen_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RST,
      ST_RTI,
      ST_HDR,
      ST_FLUSH,
      ST_ONES,
      ST_LOAD,
      ST_EXIT,
      ST_UPD,
      ST_END
   } st_e;

   typedef enum logic [1:0] {
      PH_IR,
      PH_LOAD,
      PH_DR
   } ph_e;

   localparam int unsigned RESET_TCKS = 5;
   localparam int unsigned HDR_IR_LEN = 4;   // 1,1,0,0 : idle -> Shift-IR
   localparam int unsigned HDR_DR_LEN = 3;   // 1,0,0   : idle -> Shift-DR

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/scanlen_tck_gen.sv
module scanlen_tck_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tck,
   output logic rise,
   output logic fall
);

   logic tck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tck_q <= 1'b0;
      else        tck_q <= run ? ~tck_q : 1'b0;
   end

   assign tck  = tck_q;
   assign rise = run & ~tck_q;
   assign fall = run & tck_q;

endmodule

// File: rtl/scanlen_capture.sv
module scanlen_capture #(
   parameter int unsigned W  = 4,
   parameter int unsigned VW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          ld,
   input  logic [VW-1:0] val,
   output logic [W-1:0]  q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (ld)  q <= W'(val);
   end

endmodule

// File: rtl/scanlen_ctrl.sv
module scanlen_ctrl
   import scanlen_pkg::*;
#(
   parameter int unsigned IR_MAX = 32,
   parameter int unsigned DR_MAX = 4096,
   parameter int unsigned IRW    = 6,
   parameter int unsigned CW     = 13
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           rise,
   input  logic           fall,
   input  logic           tdo,
   input  logic [IRW-1:0] ir_len,
   output logic           run,
   output logic           tms,
   output logic           tdi,
   output logic           done,
   output logic           clr,
   output logic           ir_ld,
   output logic           dr_ld,
   output logic [CW-1:0]  cnt_o,
   output logic           err_timeout,
   output logic           err_short
);

   localparam logic [CW-1:0] IR_B    = CW'(IR_MAX);
   localparam logic [CW-1:0] DR_B    = CW'(DR_MAX);
   localparam logic [CW-1:0] RST_END = CW'(RESET_TCKS - 1);

   st_e           st;
   ph_e           ph;
   logic [CW-1:0] cnt;
   logic [CW-1:0] bound;
   logic [CW-1:0] hdr_end;
   logic [CW-1:0] load_end;
   logic          tms_nx;
   logic          tdi_nx;
   logic          hit;

   assign bound    = (ph == PH_DR) ? DR_B : IR_B;
   assign hdr_end  = (ph == PH_DR) ? CW'(HDR_DR_LEN - 1) : CW'(HDR_IR_LEN - 1);
   assign load_end = CW'(ir_len) - CW'(1);
   assign hit      = rise && (st == ST_ONES) && tdo;

   always_comb begin
      tms_nx = 1'b0;
      tdi_nx = 1'b0;
      unique case (st)
         ST_RST:   tms_nx = 1'b1;
         ST_HDR:   tms_nx = (ph == PH_DR) ? (cnt == '0) : (cnt < CW'(2));
         ST_LOAD:  tms_nx = (cnt == load_end);
         ST_ONES:  tdi_nx = 1'b1;
         ST_EXIT:  tms_nx = 1'b1;
         ST_UPD:   tms_nx = 1'b1;
         default:  tms_nx = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         ph          <= PH_IR;
         cnt         <= '0;
         tms         <= 1'b0;
         tdi         <= 1'b0;
         done        <= 1'b0;
         err_timeout <= 1'b0;
         err_short   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (st == ST_IDLE) begin
            if (start) begin
               st          <= ST_RST;
               ph          <= PH_IR;
               cnt         <= '0;
               tms         <= 1'b1;
               tdi         <= 1'b0;
               err_timeout <= 1'b0;
               err_short   <= 1'b0;
            end
         end else begin
            if (fall) begin
               tms <= tms_nx;
               tdi <= tdi_nx;
            end
            if (rise) begin
               unique case (st)
                  ST_RST: begin
                     if (cnt == RST_END) begin
                        st  <= ST_RTI;
                        cnt <= '0;
                     end else cnt <= cnt + CW'(1);
                  end
                  ST_RTI: begin
                     st  <= ST_HDR;
                     cnt <= '0;
                  end
                  ST_HDR: begin
                     if (cnt == hdr_end) begin
                        st  <= (ph == PH_LOAD) ? ST_LOAD : ST_FLUSH;
                        cnt <= '0;
                     end else cnt <= cnt + CW'(1);
                  end
                  ST_FLUSH: begin
                     if (cnt == bound - CW'(1)) begin
                        st  <= ST_ONES;
                        cnt <= '0;
                     end else cnt <= cnt + CW'(1);
                  end
                  ST_ONES: begin
                     if (tdo) begin
                        st <= ST_EXIT;
                        if (ph == PH_IR && cnt < CW'(2)) err_short <= 1'b1;
                     end else if (cnt == bound) begin
                        st          <= ST_EXIT;
                        err_timeout <= 1'b1;
                     end else cnt <= cnt + CW'(1);
                  end
                  ST_LOAD: begin
                     if (cnt == load_end) begin
                        st  <= ST_UPD;
                        cnt <= '0;
                     end else cnt <= cnt + CW'(1);
                  end
                  ST_EXIT: st <= ST_UPD;
                  ST_UPD:  st <= ST_END;
                  ST_END: begin
                     cnt <= '0;
                     unique case (ph)
                        PH_IR: begin
                           if (err_timeout || err_short) begin
                              st   <= ST_IDLE;
                              done <= 1'b1;
                           end else begin
                              st <= ST_RST;
                              ph <= PH_LOAD;
                           end
                        end
                        PH_LOAD: begin
                           st <= ST_HDR;
                           ph <= PH_DR;
                        end
                        default: begin
                           st   <= ST_IDLE;
                           done <= 1'b1;
                        end
                     endcase
                  end
                  default: st <= ST_IDLE;
               endcase
            end
         end
      end
   end

   assign run   = (st != ST_IDLE);
   assign clr   = (st == ST_IDLE) && start;
   assign ir_ld = hit && (ph == PH_IR);
   assign dr_ld = hit && (ph == PH_DR);
   assign cnt_o = cnt;

endmodule

// File: rtl/scanlen_probe.sv
module scanlen_probe
   import scanlen_pkg::*;
#(
   parameter int unsigned IR_MAX = 32,
   parameter int unsigned DR_MAX = 4096
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   output logic                          busy,
   output logic                          done,
   output logic [$clog2(IR_MAX+1)-1:0]   ir_len,
   output logic [$clog2(DR_MAX+1)-1:0]   dr_len,
   output logic                          err_timeout,
   output logic                          err_short,
   output logic                          tck,
   output logic                          tms,
   output logic                          tdi,
   input  logic                          tdo
);

   localparam int unsigned IRW = $clog2(IR_MAX + 1);
   localparam int unsigned DRW = $clog2(DR_MAX + 1);
   localparam int unsigned BIG = umax(umax(IR_MAX, DR_MAX), 8);
   localparam int unsigned CW  = $clog2(BIG + 2);

   generate
      if (IR_MAX < 2) begin : g_bad_ir
         $error("scanlen_probe: IR_MAX must be at least 2");
      end
      if (DR_MAX < 1) begin : g_bad_dr
         $error("scanlen_probe: DR_MAX must be at least 1");
      end
   endgenerate

   logic          run;
   logic          rise;
   logic          fall;
   logic          clr;
   logic          ir_ld;
   logic          dr_ld;
   logic [CW-1:0] cnt;

   scanlen_tck_gen u_tck (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tck   (tck),
      .rise  (rise),
      .fall  (fall)
   );

   scanlen_ctrl #(
      .IR_MAX (IR_MAX),
      .DR_MAX (DR_MAX),
      .IRW    (IRW),
      .CW     (CW)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .rise        (rise),
      .fall        (fall),
      .tdo         (tdo),
      .ir_len      (ir_len),
      .run         (run),
      .tms         (tms),
      .tdi         (tdi),
      .done        (done),
      .clr         (clr),
      .ir_ld       (ir_ld),
      .dr_ld       (dr_ld),
      .cnt_o       (cnt),
      .err_timeout (err_timeout),
      .err_short   (err_short)
   );

   scanlen_capture #(.W(IRW), .VW(CW)) u_ir_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .ld    (ir_ld),
      .val   (cnt),
      .q     (ir_len)
   );

   scanlen_capture #(.W(DRW), .VW(CW)) u_dr_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .ld    (dr_ld),
      .val   (cnt),
      .q     (dr_len)
   );

   assign busy = run;

endmodule

// File: rtl/scanlen_probe_chk.sv
module scanlen_probe_chk #(
   parameter int unsigned IR_MAX = 32,
   parameter int unsigned DR_MAX = 4096
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        busy,
   input logic                        done,
   input logic [$clog2(IR_MAX+1)-1:0] ir_len,
   input logic [$clog2(DR_MAX+1)-1:0] dr_len,
   input logic                        err_timeout,
   input logic                        err_short,
   input logic                        tck,
   input logic                        tms,
   input logic                        tdi
);

   AST_TCK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n) busy && $past(busy) |-> tck != $past(tck)); // R2
   AST_TCK_PARKS_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |=> !tck); // R2
   AST_TMS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) busy && $past(busy) && !$fell(tck) |-> $stable(tms)); // R2
   AST_TDI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) busy && $past(busy) && !$fell(tck) |-> $stable(tdi)); // R2
   AST_START_TMS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> tms && !tck); // R3
   AST_SHORT_CLEARS_DR: assert property (@(posedge clk) disable iff (!rst_n) done && err_short |-> ir_len < 2 && dr_len == '0); // R5
   AST_VALID_IR_LEN: assert property (@(posedge clk) disable iff (!rst_n) done && !err_short && !err_timeout |-> ir_len >= 2); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
   AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !tms && !busy && $fell(busy)); // R8
   AST_RESULT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) done |-> ir_len <= IR_MAX && dr_len <= DR_MAX); // R10

endmodule

bind scanlen_probe scanlen_probe_chk #(.IR_MAX(IR_MAX), .DR_MAX(DR_MAX)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .done        (done),
   .ir_len      (ir_len),
   .dr_len      (dr_len),
   .err_timeout (err_timeout),
   .err_short   (err_short),
   .tck         (tck),
   .tms         (tms),
   .tdi         (tdi)
);

// File: tb/scanlen_probe_tb_top.sv
`timescale 1ns/1ps
module scanlen_probe_tb_top;

   localparam int IRM = 8;
   localparam int DRM = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic busy, done, err_timeout, err_short, tck, tms, tdi;
   logic tdo;
   logic [$clog2(IRM+1)-1:0] ir_len;
   logic [$clog2(DRM+1)-1:0] dr_len;

   always #10 clk = ~clk;

   scanlen_probe #(.IR_MAX(IRM), .DR_MAX(DRM)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .ir_len(ir_len), .dr_len(dr_len), .err_timeout(err_timeout),
      .err_short(err_short), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // ---------------- behavioural target TAP ----------------
   int t_ir = 4;
   int t_dr = 8;
   bit stuck = 0;
   int ts = 4;
   logic [63:0] ir_sr = '0, ir_q = '0, dr_sr = '0;
   logic byp = 1'b0;
   logic t_tdo = 1'b0;
   int uir_cnt = 0;

   function automatic int tap_next(input int s, input logic m);
      int r;
      case (s)
         0: r = m ? 0 : 1;   1: r = m ? 2 : 1;   2: r = m ? 9 : 3;   3: r = m ? 5 : 4;
         4: r = m ? 5 : 4;   5: r = m ? 8 : 6;   6: r = m ? 7 : 6;   7: r = m ? 8 : 4;
         8: r = m ? 2 : 1;   9: r = m ? 0 : 10; 10: r = m ? 12 : 11; 11: r = m ? 12 : 11;
         12: r = m ? 15 : 13; 13: r = m ? 14 : 13; 14: r = m ? 15 : 11; default: r = m ? 2 : 1;
      endcase
      return r;
   endfunction

   always @(posedge tck) begin
      logic [63:0] imask, dmask;
      logic sel;
      imask = (64'h1 << t_ir) - 64'h1;
      dmask = (64'h1 << t_dr) - 64'h1;
      sel = ((ir_q & imask) == 64'h0);
      case (ts)
         0:  ir_q = imask;
         10: ir_sr = 64'h1;
         11: ir_sr = (ir_sr >> 1) | (64'(tdi) << (t_ir - 1));
         15: begin ir_q = ir_sr & imask; uir_cnt++; end
         3:  if (sel) dr_sr = ((64'h1 << DRM) - 64'h1) & dmask; else byp = 1'b0;
         4:  if (sel) dr_sr = (dr_sr >> 1) | (64'(tdi) << (t_dr - 1)); else byp = tdi;
         default: ;
      endcase
      ts = tap_next(ts, tms);
   end

   always @(negedge tck) begin
      if (stuck)          t_tdo = 1'b0;
      else if (ts == 11)  t_tdo = ir_sr[0];
      else if (ts == 4)   t_tdo = ((ir_q & ((64'h1 << t_ir) - 64'h1)) == 64'h0) ? dr_sr[0] : byp;
      else                t_tdo = 1'b0;
   end
   assign tdo = t_tdo;

   // ---------------- pin monitors ----------------
   logic p_tck = 1'b0, p_tms = 1'b0, p_tdi = 1'b0, p_busy = 1'b0;
   int r2_bad = 0;
   int done_cnt = 0;
   int seq_n = 0;
   logic [5:0] seq = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy && p_busy && tck == p_tck) r2_bad++;
         if (busy && p_busy && !(p_tck && !tck) && (tms != p_tms || tdi != p_tdi)) r2_bad++;
         if (!busy && !p_busy && tck) r2_bad++;
         if (done) done_cnt++;
      end
      p_tck = tck; p_tms = tms; p_tdi = tdi; p_busy = busy;
   end

   always @(posedge tck) begin
      if (seq_n < 6) begin
         seq = {seq[4:0], tms};
         seq_n++;
      end
   end

   // ---------------- one measurement ----------------
   task automatic run_one(input int ir, input int dr, input bit stk, input bit restart);
      int e_ir, e_dr, e_to, e_sh, n;
      bit dr_phase;
      t_ir = ir; t_dr = dr; stuck = stk;
      if (stk || ir > IRM)  begin e_ir = 0;  e_to = 1; e_sh = 0; e_dr = 0; dr_phase = 0; end
      else if (ir < 2)      begin e_ir = ir; e_to = 0; e_sh = 1; e_dr = 0; dr_phase = 0; end
      else begin
         e_ir = ir; e_sh = 0; dr_phase = 1;
         if (dr > DRM) begin e_to = 1; e_dr = 0; end
         else          begin e_to = 0; e_dr = dr; end
      end
      @(negedge clk);
      done_cnt = 0; seq_n = 0; uir_cnt = 0; r2_bad = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
         if (restart && n == 20) start = 1'b1;
         else start = 1'b0;
      end
      start = 1'b0;
      if (n >= 5000) begin
         chk("R8 done reached", 0, 1);
      end else begin
         chk($sformatf("R4 ir_len ir=%0d dr=%0d", ir, dr), int'(ir_len), e_ir);
         chk($sformatf("R6 dr_len ir=%0d dr=%0d", ir, dr), int'(dr_len), e_dr);
         chk($sformatf("R7 err_timeout ir=%0d dr=%0d", ir, dr), int'(err_timeout), e_to);
         chk($sformatf("R5 err_short ir=%0d dr=%0d", ir, dr), int'(err_short), e_sh);
         chk("R8 target in Run-Test/Idle at done", ts, 1);
         chk("R8 busy low at done", int'(busy), 0);
         chk("R3 first six TMS bits", int'(seq), 6'b111110);
         if (dr_phase) begin
            chk("R6 latched instruction all zeros", int'(ir_q[31:0]), 0);
            chk("R6 update-IR passed", int'(uir_cnt > 0), 1);
         end
         if (ir <= IRM && !stk && dr <= DRM) begin
            chk("R10 in-range lengths exact", int'(ir_len) + int'(dr_len), e_ir + e_dr);
         end
      end
      repeat (4) @(negedge clk);
      chk("R8 R9 single done pulse", done_cnt, 1);
      chk("R9 idle after run", int'(busy), 0);
      chk("R2 pin timing", r2_bad, 0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   // ---------------- sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      chk("R1 tck in reset", int'(tck), 0);
      chk("R1 tms in reset", int'(tms), 0);
      chk("R1 busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 tdi after reset", int'(tdi), 0);
      chk("R1 done after reset", int'(done), 0);
      chk("R1 lengths after reset", int'(ir_len) + int'(dr_len), 0);
      chk("R1 flags after reset", int'(err_timeout) + int'(err_short), 0);

      for (int i = 2; i <= IRM; i++) run_one(i, 5, 0, 0);        // R4 sweep
      for (int d = 1; d <= DRM; d++) run_one(3, d, 0, 0);        // R6 sweep
      run_one(IRM, DRM, 0, 0);                                   // R10 both at bound
      run_one(1, 6, 0, 0);                                       // R5 short
      run_one(IRM + 1, 6, 0, 0);                                 // R7 IR timeout
      run_one(4, DRM + 1, 0, 0);                                 // R7 DR timeout
      run_one(4, DRM + 2, 0, 0);                                 // R7 DR timeout
      run_one(5, 7, 1, 0);                                       // R7 no device
      run_one(5, 7, 0, 1);                                       // R9 restart while busy

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule